// File: doc/BRIEF.md
# Equalization and Serration Pulse Generator

This block sits between a video timing generator and the composite sync multiplexer. It takes the running horizontal and vertical counter values, a plain horizontal sync level, a vertical sync interval flag, a two-bit mode field, a disable bit and four programmable values. From these it produces the sync stream for the composite output. Inside a programmed vertical window it replaces horizontal sync with narrow equalization pulses, or with wide serration pulses while the vertical sync flag is high. Outside the window, or when disabled, it forwards plain horizontal sync.

Pulses come either twice per line or once per line. In double mode the second pulse of a line starts at half the line length plus one, so the line length has to be even. In interlaced mode the block keeps a field flag that toggles at every frame wrap. In the odd field the window moves half a line later, so that both fields receive their pulses. The counters are 1-based, with the first clock of a line at count 1. The output is registered, so it follows its inputs with one cycle of latency.

Top module: `eqs_pulse_gen`

## Requirements
- R1: After reset is asserted, csync_o, field_o and err_o are all 0.
- R2: Outside the vertical window, csync_o equals hsync_i from one cycle earlier. The window is measured in half-lines, with half-line index 2*vcnt_i + (hcnt_i > hmax_i/2), and it covers indices 2*win_start_i through 2*win_end_i+1.
- R3: Inside the window with vsync_i low, each pulse slot drives csync_o high for slot-relative counts 1 through eq_end_i and low for the rest of the slot, whatever hsync_i is. The slot-relative count is hcnt_i in the first half of the line and hcnt_i - hmax_i/2 in the second half.
- R4: Inside the window with vsync_i high, the pulse width is taken from serr_end_i and not from eq_end_i.
- R5: In modes 00 (interlaced, double) and 01 (non-interlaced, double), a second pulse starts at hcnt_i = hmax_i/2 + 1.
- R6: In mode 11 (non-interlaced, single), only the first-half slot pulses. The second half of a line inside the window stays low.
- R7: When pulse_dis_i is 1, csync_o equals hsync_i from one cycle earlier in every line. When pulse_dis_i is 0, pulses are enabled.
- R8: Mode 10 is illegal. It behaves as mode 00 and sets err_o, which stays 1 until reset.
- R9: In interlaced operation, field_o toggles in the cycle after hcnt_i == hmax_i and vcnt_i == vmax_i. In non-interlaced modes field_o is cleared to 0 and does not toggle.
- R10: While field_o is 1 in interlaced operation, the window's half-line bounds move one half-line later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode: 00 interlaced double, 01 non-interlaced double, 10 illegal, 11 non-interlaced single |
| pulse_dis_i | input | 1 | 1 disables pulses and forwards hsync_i |
| hcnt_i | input | HW | Horizontal counter, 1..hmax_i |
| vcnt_i | input | VW | Vertical counter, 1..vmax_i |
| hmax_i | input | HW | Clocks per line (even) |
| vmax_i | input | VW | Lines per frame |
| hsync_i | input | 1 | Plain horizontal sync level, active high |
| vsync_i | input | 1 | High on lines inside the vertical sync interval |
| eq_end_i | input | HW | Equalization pulse end count within a slot |
| serr_end_i | input | HW | Serration pulse end count within a slot |
| win_start_i | input | VW | First line of the pulse window |
| win_end_i | input | VW | Last line of the pulse window |
| csync_o | output | 1 | Sync stream to the composite multiplexer |
| field_o | output | 1 | Current field, 1 for odd |
| err_o | output | 1 | Sticky flag for the illegal mode |

## Verification
The vector table holds the line and frame settings fixed and sweeps the counter position across four regions: before the window, at its first and last half-lines, inside each pulse slot, and just past each pulse end. Equalization and serration are each set against the other and against plain sync. Mode 11 and mode 01 are applied at the same second-half position, which separates the single and double slot logic. Directed tests then force a frame wrap to reach the odd field and confirm that the window edge has moved by half a line. They also apply the illegal mode and check that it acts like mode 00, that the error flag stays set, and that field_o clears once a non-interlaced mode is selected.

// File: rtl/eqs_pkg.sv
package eqs_pkg;
  typedef enum logic [1:0] {
    MODE_IL_DBL = 2'b00,
    MODE_NI_DBL = 2'b01,
    MODE_BAD    = 2'b10,
    MODE_NI_SGL = 2'b11
  } eqs_mode_e;
endpackage

// File: rtl/eqs_mode_dec.sv
module eqs_mode_dec
  import eqs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output logic       interlaced_o,
  output logic       double_o,
  output logic       err_o
);
  eqs_mode_e mode;
  logic      err_q;

  always_comb begin
    mode = eqs_mode_e'(mode_i);
    if (mode == MODE_BAD) mode = MODE_IL_DBL;
    interlaced_o = (mode == MODE_IL_DBL);
    double_o     = (mode != MODE_NI_SGL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          err_q <= 1'b0;
    else if (mode_i == 2'(MODE_BAD))      err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/eqs_field_trk.sv
module eqs_field_trk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          interlaced_i,
  input  logic [HW-1:0] hcnt_i,
  input  logic [HW-1:0] hmax_i,
  input  logic [VW-1:0] vcnt_i,
  input  logic [VW-1:0] vmax_i,
  output logic          field_o
);
  logic field_q;
  logic wrap;

  assign wrap = (hcnt_i == hmax_i) && (vcnt_i == vmax_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           field_q <= 1'b0;
    else if (!interlaced_i) field_q <= 1'b0;
    else if (wrap)         field_q <= ~field_q;
  end

  assign field_o = field_q;
endmodule

// File: rtl/eqs_slot.sv
module eqs_slot #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic [HW-1:0] hcnt_i,
  input  logic [HW-1:0] hmax_i,
  input  logic [VW-1:0] vcnt_i,
  input  logic [VW-1:0] win_start_i,
  input  logic [VW-1:0] win_end_i,
  input  logic          odd_i,
  input  logic          double_i,
  input  logic          vsync_i,
  input  logic [HW-1:0] eq_end_i,
  input  logic [HW-1:0] serr_end_i,
  output logic          win_o,
  output logic          pulse_o
);
  localparam int HLW = VW + 1;

  logic [HW-1:0]  half_pt;
  logic           second;
  logic [HW-1:0]  rel;
  logic [HW-1:0]  width;
  logic [HLW-1:0] hl_idx;
  logic [HLW-1:0] hl_lo;
  logic [HLW-1:0] hl_hi;
  logic           slot_ok;

  always_comb begin
    half_pt = hmax_i >> 1;
    second  = hcnt_i > half_pt;
    rel     = second ? (hcnt_i - half_pt) : hcnt_i;
    // odd field: window shifted half a line later
    hl_idx  = {vcnt_i, second} - HLW'(odd_i);
    hl_lo   = {win_start_i, 1'b0};
    hl_hi   = {win_end_i, 1'b1};
    win_o   = (hl_idx >= hl_lo) && (hl_idx <= hl_hi);
    width   = vsync_i ? serr_end_i : eq_end_i;
    slot_ok = double_i || !second;
    pulse_o = win_o && slot_ok && (rel != '0) && (rel <= width);
  end
endmodule

// File: rtl/eqs_pulse_gen.sv
module eqs_pulse_gen #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          pulse_dis_i,
  input  logic [HW-1:0] hcnt_i,
  input  logic [VW-1:0] vcnt_i,
  input  logic [HW-1:0] hmax_i,
  input  logic [VW-1:0] vmax_i,
  input  logic          hsync_i,
  input  logic          vsync_i,
  input  logic [HW-1:0] eq_end_i,
  input  logic [HW-1:0] serr_end_i,
  input  logic [VW-1:0] win_start_i,
  input  logic [VW-1:0] win_end_i,
  output logic          csync_o,
  output logic          field_o,
  output logic          err_o
);
  logic interlaced, dbl, field, win, pulse, csync_d, csync_q;

  eqs_mode_dec u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .interlaced_o(interlaced),
    .double_o    (dbl),
    .err_o       (err_o)
  );

  eqs_field_trk #(.HW(HW), .VW(VW)) u_field (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .interlaced_i(interlaced),
    .hcnt_i      (hcnt_i),
    .hmax_i      (hmax_i),
    .vcnt_i      (vcnt_i),
    .vmax_i      (vmax_i),
    .field_o     (field)
  );

  eqs_slot #(.HW(HW), .VW(VW)) u_slot (
    .hcnt_i     (hcnt_i),
    .hmax_i     (hmax_i),
    .vcnt_i     (vcnt_i),
    .win_start_i(win_start_i),
    .win_end_i  (win_end_i),
    .odd_i      (field & interlaced),
    .double_i   (dbl),
    .vsync_i    (vsync_i),
    .eq_end_i   (eq_end_i),
    .serr_end_i (serr_end_i),
    .win_o      (win),
    .pulse_o    (pulse)
  );

  assign csync_d = (!pulse_dis_i && win) ? pulse : hsync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csync_q <= 1'b0;
    else         csync_q <= csync_d;
  end

  assign csync_o = csync_q;
  assign field_o = field;
endmodule

// File: rtl/eqs_pulse_gen_chk.sv
module eqs_pulse_gen_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          pulse_dis_i,
  input logic [HW-1:0] hcnt_i,
  input logic [VW-1:0] vcnt_i,
  input logic [HW-1:0] hmax_i,
  input logic [VW-1:0] vmax_i,
  input logic          hsync_i,
  input logic [VW-1:0] win_start_i,
  input logic [VW-1:0] win_end_i,
  input logic          csync_o,
  input logic          field_o,
  input logic          err_o
);
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R8
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |=> err_o);

  // R7
  dis_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_dis_i |=> (csync_o == $past(hsync_i)));

  // R9
  ni_field_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 || mode_i == 2'b11) |=> !field_o);

  // R9
  il_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'b00) && (hcnt_i == hmax_i) && (vcnt_i == vmax_i))
      |=> (field_o != $past(field_o)));

  // R6
  single_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'b11) && !pulse_dis_i && (hcnt_i > (hmax_i >> 1)) &&
     (vcnt_i >= win_start_i) && (vcnt_i <= win_end_i)) |=> !csync_o);
endmodule

bind eqs_pulse_gen eqs_pulse_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .pulse_dis_i(pulse_dis_i),
  .hcnt_i     (hcnt_i),
  .vcnt_i     (vcnt_i),
  .hmax_i     (hmax_i),
  .vmax_i     (vmax_i),
  .hsync_i    (hsync_i),
  .win_start_i(win_start_i),
  .win_end_i  (win_end_i),
  .csync_o    (csync_o),
  .field_o    (field_o),
  .err_o      (err_o)
);

// File: tb/eqs_pulse_gen_tb.sv
module eqs_pulse_gen_tb;
  localparam int HW = 12;
  localparam int VW = 11;

  typedef struct packed {
    logic [1:0]    mode;
    logic          dis;
    logic          vs;
    logic          hs;
    logic [HW-1:0] h;
    logic [VW-1:0] v;
    logic          exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 1'b0, 1'b0, 1'b1, 12'd10, 11'd2, 1'b1}, // R2 before window
    '{2'b00, 1'b0, 1'b0, 1'b0, 12'd3,  11'd3, 1'b1}, // R3 eq on
    '{2'b00, 1'b0, 1'b0, 1'b1, 12'd5,  11'd3, 1'b0}, // R3 past eq end
    '{2'b00, 1'b0, 1'b0, 1'b0, 12'd53, 11'd3, 1'b1}, // R5 second pulse
    '{2'b00, 1'b0, 1'b0, 1'b1, 12'd50, 11'd3, 1'b0}, // R3 overrides hsync
    '{2'b00, 1'b0, 1'b0, 1'b0, 12'd51, 11'd3, 1'b1}, // R5 starts at hmax/2+1
    '{2'b00, 1'b0, 1'b1, 1'b0, 12'd30, 11'd5, 1'b1}, // R4 serration wide
    '{2'b00, 1'b0, 1'b1, 1'b1, 12'd45, 11'd5, 1'b0}, // R4 past serr end
    '{2'b00, 1'b0, 1'b1, 1'b0, 12'd80, 11'd5, 1'b1}, // R4 R5 second serr
    '{2'b11, 1'b0, 1'b0, 1'b0, 12'd53, 11'd3, 1'b0}, // R6 single quiet
    '{2'b11, 1'b0, 1'b0, 1'b0, 12'd2,  11'd3, 1'b1}, // R6 single first
    '{2'b01, 1'b0, 1'b0, 1'b0, 12'd53, 11'd3, 1'b1}, // R5 ni double
    '{2'b00, 1'b1, 1'b0, 1'b0, 12'd53, 11'd3, 1'b0}, // R7 disabled low
    '{2'b00, 1'b1, 1'b0, 1'b1, 12'd60, 11'd3, 1'b1}, // R7 disabled high
    '{2'b00, 1'b0, 1'b0, 1'b0, 12'd53, 11'd8, 1'b1}, // R2 last half-line
    '{2'b00, 1'b0, 1'b0, 1'b1, 12'd2,  11'd9, 1'b1}  // R2 after window
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          dis = 1'b0, hs = 1'b0, vs = 1'b0;
  logic [HW-1:0] hcnt = 12'd1;
  logic [VW-1:0] vcnt = 11'd1;
  logic          csync, field, err;
  int nchk = 0, nbad = 0;

  always #5 clk = ~clk;

  eqs_pulse_gen #(.HW(HW), .VW(VW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .pulse_dis_i(dis),
    .hcnt_i(hcnt), .vcnt_i(vcnt), .hmax_i(12'd100), .vmax_i(11'd20),
    .hsync_i(hs), .vsync_i(vs), .eq_end_i(12'd4), .serr_end_i(12'd40),
    .win_start_i(11'd3), .win_end_i(11'd8),
    .csync_o(csync), .field_o(field), .err_o(err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic d, input logic v,
                      input logic h, input logic [HW-1:0] hc, input logic [VW-1:0] vc);
    mode = m; dis = d; vs = v; hs = h; hcnt = hc; vcnt = vc;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 csync", csync, 1'b0);
    chk("R1 field", field, 1'b0);
    chk("R1 err", err, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].mode, VEC[i].dis, VEC[i].vs, VEC[i].hs, VEC[i].h, VEC[i].v);
      chk($sformatf("R2-table vec %0d", i), csync, VEC[i].exp);
    end

    // R8: illegal mode acts as 00 and sets sticky error
    step(2'b10, 1'b0, 1'b0, 1'b0, 12'd53, 11'd3);
    chk("R8 acts as double", csync, 1'b1);
    chk("R8 err set", err, 1'b1);
    step(2'b00, 1'b0, 1'b0, 1'b0, 12'd10, 11'd1);
    chk("R8 err sticky", err, 1'b1);

    // R9: wrap toggles field in interlaced mode
    step(2'b00, 1'b0, 1'b0, 1'b0, 12'd100, 11'd20);
    chk("R9 field toggled", field, 1'b1);
    // R10: odd field window shifted half a line
    step(2'b00, 1'b0, 1'b0, 1'b1, 12'd10, 11'd3);
    chk("R10 first half-line now outside", csync, 1'b1);
    step(2'b00, 1'b0, 1'b0, 1'b0, 12'd53, 11'd3);
    chk("R10 second half of line 3 inside", csync, 1'b1);
    step(2'b00, 1'b0, 1'b0, 1'b0, 12'd2, 11'd9);
    chk("R10 line 9 first half inside", csync, 1'b1);
    step(2'b00, 1'b0, 1'b0, 1'b0, 12'd53, 11'd9);
    chk("R10 line 9 second half outside", csync, 1'b0);
    chk("R9 field held", field, 1'b1);

    // R9: non-interlaced clears field and ignores wrap
    step(2'b01, 1'b0, 1'b0, 1'b0, 12'd100, 11'd20);
    chk("R9 ni clear", field, 1'b0);
    step(2'b01, 1'b0, 1'b0, 1'b0, 12'd100, 11'd20);
    chk("R9 ni no toggle", field, 1'b0);

    // R1: reset clears sticky error
    rst_n = 1'b0; #2;
    chk("R1 err cleared", err, 1'b0);
    chk("R1 csync cleared", csync, 1'b0);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule